// File: doc/BRIEF.md
# Configurable Modular Adder

The block adds two residues and returns their sum reduced modulo one of four moduli, picked per operation by a two-bit mode input. Three modes tie the modulus to the operand width k: 2^k (carry dropped), 2^k - 1 (carry wrapped back into the least significant bit), and 2^k + 1 (operands and result held in a (k+1)-bit diminished-1 form). The fourth mode reduces modulo a fixed constant set by a parameter. It computes the plain sum and the sum minus the constant side by side and keeps the difference when that difference is not negative.

The reduction is combinational. The result is registered once, so it appears on the output one clock after the operands and mode are presented, and a new operation can start every cycle. Operands must already lie in the residue range of the selected mode. All modes share one k-bit carry-propagate adder and one incrementer. Only the constant-modulus mode adds a carry-save stage and a second, wider adder.

Top module: `modadd_unit`

## Requirements
- R1: While rst_ni is low, res_o is zero. res_o changes only at a rising clock edge. It shows the result of the mode_i, x_i and y_i values present at that edge.
- R2: Mode 0 (2'b00): res_o = (x_i[k-1:0] + y_i[k-1:0]) mod 2^k, and res_o[k] = 0.
- R3: Mode 1 (2'b01): res_o = (x + y) mod (2^k - 1). An operand may be any k-bit value, and the all-ones value is read as zero.
- R4: Mode 1: the output is never the all-ones pattern. A sum equal to 2^k - 1, or two all-ones operands, gives 0, and res_o[k] = 0.
- R5: Mode 2 (2'b10) uses diminished-1 encoding with k+1 bits. A code with bit k set and the low bits zero stands for 0. Any other code has bit k clear and stores value - 1 in its low k bits. res_o is the code of (x + y) mod (2^k + 1).
- R6: Mode 2: if one operand is the zero code, res_o equals the other operand's code. If both operands are the zero code, res_o is the zero code.
- R7: Mode 2: when the values sum to exactly 2^k + 1, res_o is the zero code {1'b1, k zeros}. When they sum to more than that, the result wraps correctly.
- R8: Mode 3 (2'b11): for operands below MOD_GEN, res_o = (x + y) mod MOD_GEN, so it is always below MOD_GEN.
- R9: Mode 3 at the boundaries: a sum equal to MOD_GEN gives 0, a sum of MOD_GEN - 1 is passed through unchanged, and the largest sum (2*MOD_GEN - 2) gives MOD_GEN - 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the result register captures on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset of the result register |
| mode_i | input | 2 | Modulus select: 0 = 2^k, 1 = 2^k-1, 2 = 2^k+1 (diminished-1), 3 = MOD_GEN |
| x_i | input | DATA_W+1 | First operand; bit DATA_W is the zero flag in mode 2 and must be 0 otherwise |
| y_i | input | DATA_W+1 | Second operand; same encoding as x_i |
| res_o | output | DATA_W+1 | Reduced sum, registered |

## Verification
Each mode gets directed pairs placed on the wrap points: a sum just under the modulus, exactly at it, and at its largest legal value. These separate a correct end-around or select decision from an off-by-one in the carry handling. The 2^k - 1 mode also gets the alternate all-ones zero as input, and the diminished-1 mode gets zero-code operands on either side and on both sides. These exercise the bypass path apart from the incremented sum. Long runs of random legal operands in every mode, with the mode changing every cycle, then check the shared adder and incrementer against an integer reference. This catches a mode-select or register-timing fault that the directed pairs alone would miss.

// File: rtl/modadd_pkg.sv
package modadd_pkg;
  typedef enum logic [1:0] {
    MODE_POW2    = 2'b00,
    MODE_POW2_M1 = 2'b01,
    MODE_POW2_P1 = 2'b10,
    MODE_GEN     = 2'b11
  } mod_mode_e;
endpackage

// File: rtl/modadd_prefix_add.sv
// Log-depth parallel-prefix adder with carry-in folded into bit 0
module modadd_prefix_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int LV = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] p0, g0;
  logic [W-1:0] g_acc, p_acc, g_nxt, p_nxt;
  logic [W-1:0] cin_vec;

  assign p0 = a_i ^ b_i;
  always_comb begin
    g0    = a_i & b_i;
    g0[0] = (a_i[0] & b_i[0]) | (p0[0] & cin_i);
  end

  always_comb begin
    g_acc = g0;
    p_acc = p0;
    g_nxt = g0;
    p_nxt = p0;
    for (int lv = 0; lv < LV; lv++) begin
      g_nxt = g_acc;
      p_nxt = p_acc;
      for (int i = 0; i < W; i++) begin
        if (i >= (1 << lv)) begin
          g_nxt[i] = g_acc[i] | (p_acc[i] & g_acc[i-(1<<lv)]);
          p_nxt[i] = p_acc[i] & p_acc[i-(1<<lv)];
        end
      end
      g_acc = g_nxt;
      p_acc = p_nxt;
    end
  end

  generate
    if (W > 1) begin : g_cvec
      assign cin_vec = {g_acc[W-2:0], cin_i};
    end else begin : g_cone
      assign cin_vec = cin_i;
    end
  endgenerate

  assign sum_o  = p0 ^ cin_vec;
  assign cout_o = g_acc[W-1];
endmodule

// File: rtl/modadd_csa.sv
// 3:2 carry-save compressor; carry vector is pre-shifted, top carry dropped
module modadd_csa #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cy_o
);
  assign cy_o[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c_i[i];
    if (i < W - 1) begin : g_cy
      assign cy_o[i+1] = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
    end
  end
endmodule

// File: rtl/modadd_incr.sv
// Conditional +1 with carry out
module modadd_incr #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         inc_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] run;
  assign run[0] = inc_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i]  = a_i[i] ^ run[i];
    assign run[i+1]  = a_i[i] & run[i];
  end
  assign cout_o = run[W];
endmodule

// File: rtl/modadd_unit.sv
module modadd_unit
  import modadd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MOD_GEN = 200   // 2 <= MOD_GEN <= 2**DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W:0]   x_i,
  input  logic [DATA_W:0]   y_i,
  output logic [DATA_W:0]   res_o
);
  localparam int OPW = DATA_W + 1;
  localparam int GW  = DATA_W + 2;
  localparam logic [GW-1:0] NEG_M = GW'((1 << GW) - MOD_GEN);

  mod_mode_e mode;
  assign mode = mod_mode_e'(mode_i);

  // Shared k-bit adder for all modes
  logic [DATA_W-1:0] low_sum;
  logic              low_co;
  modadd_prefix_add #(.W(DATA_W)) u_low (
    .a_i   (x_i[DATA_W-1:0]),
    .b_i   (y_i[DATA_W-1:0]),
    .cin_i (1'b0),
    .sum_o (low_sum),
    .cout_o(low_co)
  );

  // End-around carry (2^k-1) or inverted end-around carry (diminished-1)
  logic inc_en;
  always_comb begin
    unique case (mode)
      MODE_POW2_M1: inc_en = low_co;
      MODE_POW2_P1: inc_en = ~low_co;
      default:      inc_en = 1'b0;
    endcase
  end

  logic [DATA_W-1:0] inc_sum;
  logic              inc_co;
  modadd_incr #(.W(DATA_W)) u_inc (
    .a_i   (low_sum),
    .inc_i (inc_en),
    .sum_o (inc_sum),
    .cout_o(inc_co)
  );

  // General modulus: x + y - m via carry-save fold, then one wide add
  logic [GW-1:0] csa_s, csa_c, diff;
  logic          unused_diff_co;
  modadd_csa #(.W(GW)) u_csa (
    .a_i  ({1'b0, x_i}),
    .b_i  ({1'b0, y_i}),
    .c_i  (NEG_M),
    .sum_o(csa_s),
    .cy_o (csa_c)
  );
  modadd_prefix_add #(.W(GW)) u_diff (
    .a_i   (csa_s),
    .b_i   (csa_c),
    .cin_i (1'b0),
    .sum_o (diff),
    .cout_o(unused_diff_co)
  );

  logic diff_neg, m1_all_ones, x_zero, y_zero;
  assign diff_neg    = diff[GW-1];
  assign m1_all_ones = &inc_sum;
  assign x_zero      = x_i[DATA_W];
  assign y_zero      = y_i[DATA_W];

  logic [OPW-1:0] res_d;
  always_comb begin
    unique case (mode)
      MODE_POW2:    res_d = {1'b0, low_sum};
      MODE_POW2_M1: res_d = m1_all_ones ? '0 : {1'b0, inc_sum};
      MODE_POW2_P1: begin
        if (x_zero)      res_d = y_i;
        else if (y_zero) res_d = x_i;
        else             res_d = {inc_co, inc_sum};
      end
      default:      res_d = diff_neg ? {low_co, low_sum} : diff[OPW-1:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else         res_o <= res_d;
  end
endmodule

// File: rtl/modadd_unit_chk.sv
module modadd_unit_chk #(
  parameter int DATA_W  = 8,
  parameter int MOD_GEN = 200
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      mode_i,
  input logic [DATA_W:0] x_i,
  input logic [DATA_W:0] y_i,
  input logic [DATA_W:0] res_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_zero_R1: assert (res_o == '0);
  end

  assert_pow2_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(mode_i) == 2'b00) |->
      (res_o == {1'b0, DATA_W'($past(x_i[DATA_W-1:0]) + $past(y_i[DATA_W-1:0]))}));

  assert_m1_no_ones_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(mode_i) == 2'b01) |->
      (res_o[DATA_W] == 1'b0 && res_o[DATA_W-1:0] != {DATA_W{1'b1}}));

  assert_dim1_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(mode_i) == 2'b10 && $past(x_i[DATA_W])) |-> (res_o == $past(y_i)));

  assert_dim1_exact_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(mode_i) == 2'b10 && !$past(x_i[DATA_W]) && !$past(y_i[DATA_W]) &&
     ({1'b0, $past(x_i[DATA_W-1:0])} + {1'b0, $past(y_i[DATA_W-1:0])}) == {1'b0, {DATA_W{1'b1}}})
      |-> (res_o == {1'b1, {DATA_W{1'b0}}}));

  assert_gen_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(mode_i) == 2'b11) |-> (int'(res_o) < MOD_GEN));
endmodule

bind modadd_unit modadd_unit_chk #(.DATA_W(DATA_W), .MOD_GEN(MOD_GEN)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .mode_i(mode_i),
  .x_i   (x_i),
  .y_i   (y_i),
  .res_o (res_o)
);

// File: tb/sim_modadd_unit.sv
`timescale 1ns/1ps
module sim_modadd_unit;
  localparam int K = 8;
  localparam int M = 200;
  localparam int LIMIT = 20000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic [K:0]   x_i = '0;
  logic [K:0]   y_i = '0;
  logic [K:0]   res_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  modadd_unit #(.DATA_W(K), .MOD_GEN(M)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .x_i(x_i), .y_i(y_i), .res_o(res_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int dim1_dec(int c);
    return ((c >> K) & 1) ? 0 : (c & ((1 << K) - 1)) + 1;
  endfunction

  function automatic int ref_res(int mode, int x, int y);
    int lo, xv, yv, v;
    lo = (1 << K) - 1;
    case (mode)
      0: return ((x & lo) + (y & lo)) % (1 << K);
      1: begin
        xv = (x == lo) ? 0 : x;
        yv = (y == lo) ? 0 : y;
        return (xv + yv) % lo;
      end
      2: begin
        v = (dim1_dec(x) + dim1_dec(y)) % ((1 << K) + 1);
        return (v == 0) ? (1 << K) : v - 1;
      end
      default: return (x + y) % M;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s mode=%0d x=%0h y=%0h actual=%0h expected=%0h",
               req, mode_i, x_i, y_i, act, exp);
    end
  endtask

  // Drive at negedge, compare one clock later at the next negedge
  task automatic op(string req, int mode, int x, int y);
    int exp;
    mode_i = mode[1:0];
    x_i    = x[K:0];
    y_i    = y[K:0];
    exp    = ref_res(mode, x, y);
    @(negedge clk_i);
    check(req, int'(res_o), exp);
  endtask

  function automatic int rnd_op(int mode);
    int r;
    r = $urandom;
    case (mode)
      0, 1: return r & ((1 << K) - 1);
      2:    return ((r & 7) == 0) ? (1 << K) : ((r >> 3) & ((1 << K) - 1));
      default: return (r & 32'h7fff_ffff) % M;
    endcase
  endfunction

  initial begin
    int prev;
    mode_i = 2'd0; x_i = 9'h0ff; y_i = 9'h0ff;
    repeat (3) @(negedge clk_i);
    check("R1", int'(res_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: registered, one clock of latency
    op("R1", 0, 8'h12, 8'h34);
    prev = int'(res_o);
    mode_i = 2'd0; x_i = 9'h001; y_i = 9'h001;
    #2;
    check("R1", int'(res_o), prev);
    @(negedge clk_i);
    check("R1", int'(res_o), 2);

    // R2
    op("R2", 0, 8'hff, 8'h01);
    op("R2", 0, 8'h80, 8'h80);
    op("R2", 0, 8'h7f, 8'h80);
    // R3
    op("R3", 1, 5, 7);
    op("R3", 1, 8'hff, 5);
    op("R3", 1, 8'hfe, 2);
    op("R3", 1, 8'hfe, 8'hfe);
    // R4
    op("R4", 1, 8'h80, 8'h7f);
    op("R4", 1, 8'hff, 8'hff);
    op("R4", 1, 0, 8'hff);
    // R5
    op("R5", 2, 3, 4);
    op("R5", 2, 0, 0);
    op("R5", 2, 8'hff, 8'hff);
    // R6
    op("R6", 2, 9'h100, 8'h42);
    op("R6", 2, 8'h17, 9'h100);
    op("R6", 2, 9'h100, 9'h100);
    // R7
    op("R7", 2, 8'h80, 8'h7f);
    op("R7", 2, 8'hfe, 8'h01);
    op("R7", 2, 8'h80, 8'h80);
    // R8
    op("R8", 3, 150, 100);
    op("R8", 3, 0, 0);
    op("R8", 3, 17, 42);
    // R9
    op("R9", 3, 120, 80);
    op("R9", 3, 120, 79);
    op("R9", 3, M - 1, M - 1);
    op("R9", 3, M - 1, 1);

    // Random legal operands with the mode changing every cycle
    for (int n = 0; n < 4000; n++) begin
      int md;
      md = n % 4;
      case (md)
        0: op("R2", md, rnd_op(md), rnd_op(md));
        1: op("R3", md, rnd_op(md), rnd_op(md));
        2: op("R5", md, rnd_op(md), rnd_op(md));
        default: op("R8", md, rnd_op(md), rnd_op(md));
      endcase
    end

    // R1: asynchronous reset clears the output
    #2 rst_ni = 1'b0;
    #1 check("R1", int'(res_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule